// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits behind a bank of timer channels and turns each channel's match event into an interrupt. Every channel carries a small configuration: a route field that names the interrupt line it drives, a level or edge signalling choice, and an optional message mode. In message mode the event becomes a 32-bit write request instead of a line. Level-type events latch a status bit that software clears by writing ones to a status register. Edge-type events produce a single-cycle pulse.

A legacy replacement mode serves platforms that expect the timer to stand in for an older interval timer and a real-time clock. When it is on, channel 0 is pinned to line 0, channel 1 is pinned to line 8, and two external legacy interrupt inputs are blocked from those lines. A legacy-timer enable output tells the older timer to stay quiet. The second legacy input is sampled every cycle, so that line 8 shows its current level again as soon as the mode is switched off.

All state is sampled on the rising clock edge. Lines, status and the message request reflect each event or write one clock after the edge that samples it. The bus master that carries out the message write is a separate block, and it acknowledges each request.

Top module: `timer_irq_router`

## Requirements
- R1: Outside legacy mode, an event on a channel whose route field holds value n acts on line n (one route field of clog2(NUM_LINES) bits per channel).
- R2: An event on an enabled level-type channel (`chLevel`=1, `chMsgEn`=0) sets that channel's bit in `statusBits` one clock later, and the routed line stays high for as long as the bit stays set.
- R3: An event on an enabled edge-type channel (`chLevel`=0, `chMsgEn`=0) drives its routed line high for exactly one clock and leaves that channel's status bit clear.
- R4: An event on an enabled channel with `chMsgEn`=1 raises `msgValid`, with `msgAddr` set to bits 63:32 and `msgData` set to bits 31:0 of that channel's message word. It drives no line and sets no status bit. A request stays valid until `msgAck` is seen. When several are pending, the lowest-numbered channel goes first.
- R5: A cycle with `statusWrEn`=1 clears exactly the status bits where `statusWrData` is 1 and leaves the other bits as they are. Each cleared channel's line drops. If a level event and a clear for the same channel arrive in the same cycle, the event wins.
- R6: While a channel's enable or `globalEn` is low, that channel's status bit is cleared, its line is released and its events are ignored.
- R7: In legacy mode, channel 0 acts on line 0 and channel 1 acts on line 8, whatever their route fields hold. Other channels keep using their route fields.
- R8: `legacyTimerEn` is the inverse of `legacyMode` as sampled on the previous clock edge.
- R9: Outside legacy mode, `legIn0` reaches line 0 and `legIn1` reaches line 8 one clock after sampling. In legacy mode both are blocked. `legIn1` is sampled in every mode, so on leaving legacy mode line 8 takes its current level at once.
- R10: After reset, all lines, status bits and message requests are low, and `legacyTimerEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chMatch | input | NUM_CH | Per-channel match event, one clock wide |
| chEnable | input | NUM_CH | Per-channel interrupt enable |
| chLevel | input | NUM_CH | 1 = level signalling, 0 = edge signalling |
| chMsgEn | input | NUM_CH | 1 = deliver event as message write |
| chRoute | input | NUM_CH x clog2(NUM_LINES) | Per-channel target line |
| chMsgWord | input | NUM_CH x 64 | Per-channel message word: address in 63:32, data in 31:0 |
| globalEn | input | 1 | Global interrupt enable |
| legacyMode | input | 1 | Legacy replacement mode |
| legIn0 | input | 1 | First external legacy interrupt input |
| legIn1 | input | 1 | Second external legacy interrupt input |
| statusWrEn | input | 1 | Status register write strobe |
| statusWrData | input | NUM_CH | Write-one-to-clear mask |
| msgAck | input | 1 | Acknowledge for the current message request |
| irqLines | output | NUM_LINES | Interrupt lines |
| statusBits | output | NUM_CH | Level status register |
| legacyTimerEn | output | 1 | Enable for the older interval timer |
| msgValid | output | 1 | Message request pending |
| msgAddr | output | 32 | Message write address |
| msgData | output | 32 | Message write data |

## Verification
The bench focuses on the legacy transitions. A design that overrode the routes of the wrong channels would light lines 3 and 4 instead of 0 and 8. A design that stopped sampling the second legacy input while legacy mode was on would leave line 8 low after exit. Write-one-to-clear selectivity and the priority of a same-cycle event over a clear are both checked: a plain register write would wipe unrelated bits, and the wrong priority would lose an interrupt. The bench also confirms that an edge pulse lasts exactly one clock, and that a message held without acknowledge keeps its address and data stable and never touches a line.

// File: rtl/tir_pkg.sv
package tir_pkg;

  typedef enum logic [1:0] {
    ROUTE_FIELD = 2'd0,
    ROUTE_LEG_A = 2'd1,
    ROUTE_LEG_B = 2'd2
  } routeSel_t;

  // Channels 0 and 1 are taken over while the legacy mode is active.
  function automatic routeSel_t pickRoute(input int ch, input logic legacy);
    if (legacy && ch == 0) return ROUTE_LEG_A;
    if (legacy && ch == 1) return ROUTE_LEG_B;
    return ROUTE_FIELD;
  endfunction

  localparam int STRB_FIELDS = 6;

endpackage

// File: rtl/tir_ctrl.sv
module tir_ctrl #(
  parameter int NUM_CH = 4,
  localparam int STRB_W = tir_pkg::STRB_FIELDS * NUM_CH
) (
  input  logic [NUM_CH-1:0] chMatch,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] chLevel,
  input  logic [NUM_CH-1:0] chMsgEn,
  input  logic              globalEn,
  input  logic              statusWrEn,
  input  logic [NUM_CH-1:0] statusWrData,
  input  logic              msgAck,
  input  logic [NUM_CH-1:0] pending,
  output logic [STRB_W-1:0] strbBus
);

  typedef struct packed {
    logic [NUM_CH-1:0] setStat;
    logic [NUM_CH-1:0] clrStat;
    logic [NUM_CH-1:0] firePulse;
    logic [NUM_CH-1:0] queueMsg;
    logic [NUM_CH-1:0] dropMsg;
    logic [NUM_CH-1:0] grant;
  } strb_t;

  strb_t strb;
  logic  found;
  logic  live;
  logic  evt;

  always_comb begin
    strb  = '0;
    found = 1'b0;
    live  = 1'b0;
    evt   = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      live = chEnable[c] & globalEn;
      evt  = chMatch[c] & live;
      strb.setStat[c]   = evt & chLevel[c] & ~chMsgEn[c];
      strb.firePulse[c] = evt & ~chLevel[c] & ~chMsgEn[c];
      strb.queueMsg[c]  = evt & chMsgEn[c];
      strb.clrStat[c]   = ~live | (statusWrEn & statusWrData[c]) |
                          strb.firePulse[c];
      if (pending[c] && !found) begin
        strb.grant[c] = 1'b1;
        found = 1'b1;
      end
    end
    strb.dropMsg = strb.grant & {NUM_CH{msgAck}};
  end

  assign strbBus = strb;

endmodule

// File: rtl/tir_datapath.sv
module tir_datapath #(
  parameter int NUM_CH     = 4,
  parameter int NUM_LINES  = 16,
  parameter int LEG_LINE_A = 0,
  parameter int LEG_LINE_B = 8,
  localparam int RW     = $clog2(NUM_LINES),
  localparam int STRB_W = tir_pkg::STRB_FIELDS * NUM_CH
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [STRB_W-1:0]            strbBus,
  input  logic [NUM_CH-1:0][RW-1:0]    chRoute,
  input  logic [NUM_CH-1:0][63:0]      chMsgWord,
  input  logic                         legacyMode,
  input  logic                         legIn0,
  input  logic                         legIn1,
  output logic [NUM_CH-1:0]            pending,
  output logic [NUM_LINES-1:0]         irqLines,
  output logic [NUM_CH-1:0]            statusBits,
  output logic                         legacyTimerEn,
  output logic                         msgValid,
  output logic [31:0]                  msgAddr,
  output logic [31:0]                  msgData
);
  import tir_pkg::*;

  typedef struct packed {
    logic [NUM_CH-1:0] setStat;
    logic [NUM_CH-1:0] clrStat;
    logic [NUM_CH-1:0] firePulse;
    logic [NUM_CH-1:0] queueMsg;
    logic [NUM_CH-1:0] dropMsg;
    logic [NUM_CH-1:0] grant;
  } strb_t;

  strb_t strb;
  assign strb = strb_t'(strbBus);

  logic [NUM_CH-1:0] statQ;
  logic [NUM_CH-1:0] pulseQ;
  logic [NUM_CH-1:0] pendQ;
  logic              legacyQ;
  logic              leg0Q;
  logic              leg1Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ   <= '0;
      pulseQ  <= '0;
      pendQ   <= '0;
      legacyQ <= 1'b0;
      leg0Q   <= 1'b0;
      leg1Q   <= 1'b0;
    end else begin
      statQ   <= (statQ & ~strb.clrStat) | strb.setStat;
      pulseQ  <= strb.firePulse;
      pendQ   <= (pendQ & ~strb.dropMsg) | strb.queueMsg;
      legacyQ <= legacyMode;
      leg0Q   <= legIn0;
      leg1Q   <= legIn1;
    end
  end

  // Effective target line per channel
  logic [NUM_CH-1:0][RW-1:0] effRoute;
  logic [NUM_CH-1:0]         active;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      unique case (pickRoute(c, legacyQ))
        ROUTE_LEG_A: effRoute[c] = RW'(LEG_LINE_A);
        ROUTE_LEG_B: effRoute[c] = RW'(LEG_LINE_B);
        default:     effRoute[c] = chRoute[c];
      endcase
    end
  end

  assign active = statQ | pulseQ;

  for (genvar L = 0; L < NUM_LINES; L++) begin : g_line
    logic chHit;
    logic legHit;
    always_comb begin
      chHit = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (active[c] && effRoute[c] == RW'(L)) chHit = 1'b1;
      end
    end
    if (L == LEG_LINE_A) begin : g_legA
      assign legHit = ~legacyQ & leg0Q;
    end else if (L == LEG_LINE_B) begin : g_legB
      assign legHit = ~legacyQ & leg1Q;
    end else begin : g_plain
      assign legHit = 1'b0;
    end
    assign irqLines[L] = chHit | legHit;
  end

  // Message payload from the granted channel
  always_comb begin
    msgAddr = '0;
    msgData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strb.grant[c]) begin
        msgAddr = chMsgWord[c][63:32];
        msgData = chMsgWord[c][31:0];
      end
    end
  end

  assign pending       = pendQ;
  assign msgValid      = |pendQ;
  assign statusBits    = statQ;
  assign legacyTimerEn = ~legacyQ;

endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router #(
  parameter int NUM_CH     = 4,
  parameter int NUM_LINES  = 16,
  parameter int LEG_LINE_A = 0,
  parameter int LEG_LINE_B = 8,
  localparam int RW     = $clog2(NUM_LINES),
  localparam int STRB_W = tir_pkg::STRB_FIELDS * NUM_CH
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         chMatch,
  input  logic [NUM_CH-1:0]         chEnable,
  input  logic [NUM_CH-1:0]         chLevel,
  input  logic [NUM_CH-1:0]         chMsgEn,
  input  logic [NUM_CH-1:0][RW-1:0] chRoute,
  input  logic [NUM_CH-1:0][63:0]   chMsgWord,
  input  logic                      globalEn,
  input  logic                      legacyMode,
  input  logic                      legIn0,
  input  logic                      legIn1,
  input  logic                      statusWrEn,
  input  logic [NUM_CH-1:0]         statusWrData,
  input  logic                      msgAck,
  output logic [NUM_LINES-1:0]      irqLines,
  output logic [NUM_CH-1:0]         statusBits,
  output logic                      legacyTimerEn,
  output logic                      msgValid,
  output logic [31:0]               msgAddr,
  output logic [31:0]               msgData
);

  logic [STRB_W-1:0] strbBus;
  logic [NUM_CH-1:0] pending;

  tir_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .chMatch      (chMatch),
    .chEnable     (chEnable),
    .chLevel      (chLevel),
    .chMsgEn      (chMsgEn),
    .globalEn     (globalEn),
    .statusWrEn   (statusWrEn),
    .statusWrData (statusWrData),
    .msgAck       (msgAck),
    .pending      (pending),
    .strbBus      (strbBus)
  );

  tir_datapath #(
    .NUM_CH     (NUM_CH),
    .NUM_LINES  (NUM_LINES),
    .LEG_LINE_A (LEG_LINE_A),
    .LEG_LINE_B (LEG_LINE_B)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strbBus       (strbBus),
    .chRoute       (chRoute),
    .chMsgWord     (chMsgWord),
    .legacyMode    (legacyMode),
    .legIn0        (legIn0),
    .legIn1        (legIn1),
    .pending       (pending),
    .irqLines      (irqLines),
    .statusBits    (statusBits),
    .legacyTimerEn (legacyTimerEn),
    .msgValid      (msgValid),
    .msgAddr       (msgAddr),
    .msgData       (msgData)
  );

endmodule

// File: rtl/tir_checker.sv
module tir_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chMatch,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] chLevel,
  input logic [NUM_CH-1:0] chMsgEn,
  input logic              globalEn,
  input logic              legacyMode,
  input logic [NUM_CH-1:0] statusBits,
  input logic              legacyTimerEn,
  input logic              msgValid,
  input logic              msgAck
);

  logic [NUM_CH-1:0] liveEvt;
  logic [NUM_CH-1:0] lvlEvt;
  logic [NUM_CH-1:0] edgeEvt;

  assign liveEvt = chMatch & chEnable & {NUM_CH{globalEn}};
  assign lvlEvt  = liveEvt & chLevel & ~chMsgEn;
  assign edgeEvt = liveEvt & ~chLevel & ~chMsgEn;

  AST_LEVEL_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (lvlEvt != '0) |=> ((statusBits & $past(lvlEvt)) == $past(lvlEvt))); // R2

  AST_EDGE_LEAVES_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (edgeEvt != '0) |=> ((statusBits & $past(edgeEvt)) == '0)); // R3

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgAck) |=> msgValid); // R4

  AST_GLOBAL_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> (statusBits == '0)); // R6

  AST_LEGACY_TIMER_EN: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (legacyTimerEn == !$past(legacyMode))); // R8

endmodule

bind timer_irq_router tir_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .chMatch       (chMatch),
  .chEnable      (chEnable),
  .chLevel       (chLevel),
  .chMsgEn       (chMsgEn),
  .globalEn      (globalEn),
  .legacyMode    (legacyMode),
  .statusBits    (statusBits),
  .legacyTimerEn (legacyTimerEn),
  .msgValid      (msgValid),
  .msgAck        (msgAck)
);

// File: tb/timer_irq_router_tb.sv
`timescale 1ns/1ps
module timer_irq_router_tb_top;
  localparam int NC = 4;
  localparam int NL = 16;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0] chMatch = '0, chEnable = '0, chLevel = '0, chMsgEn = '0;
  logic [NC-1:0][RW-1:0] chRoute = '0;
  logic [NC-1:0][63:0] chMsgWord = '0;
  logic globalEn = 1'b0, legacyMode = 1'b0, legIn0 = 1'b0, legIn1 = 1'b0;
  logic statusWrEn = 1'b0, msgAck = 1'b0;
  logic [NC-1:0] statusWrData = '0;
  logic [NL-1:0] irqLines;
  logic [NC-1:0] statusBits;
  logic legacyTimerEn, msgValid;
  logic [31:0] msgAddr, msgData;

  always #2.5 clk = ~clk;

  timer_irq_router #(.NUM_CH(NC), .NUM_LINES(NL)) dut_i (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Bench model state
  logic [NC-1:0] mStat = '0, mPulse = '0, mPend = '0;
  logic mLeg = 1'b0, mL0 = 1'b0, mL1 = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] expLines();
    logic [NL-1:0] l = '0;
    int r;
    for (int c = 0; c < NC; c++) begin
      r = (mLeg && c == 0) ? 0 : (mLeg && c == 1) ? 8 : int'(chRoute[c]);
      if (mStat[c] || mPulse[c]) l[r] = 1'b1;
    end
    if (!mLeg) begin
      l[0] = l[0] | mL0;
      l[8] = l[8] | mL1;
    end
    return l;
  endfunction

  task automatic compareAll();
    logic [NC-1:0] g;
    g = mPend & (~mPend + 1'b1);
    chk("R1 R2 R3 R7 R9 lines", irqLines, expLines());
    chk("R2 R5 R6 status", statusBits, mStat);
    chk("R8 legacyTimerEn", legacyTimerEn, !mLeg);
    chk("R4 msgValid", msgValid, |mPend);
    for (int c = 0; c < NC; c++)
      if (g[c]) chk("R4 msg payload", {msgAddr, msgData}, chMsgWord[c]);
  endtask

  task automatic step();
    logic [NC-1:0] live, evt, setv, fire, q, g, clr, nStat, nPend;
    live = chEnable & {NC{globalEn}};
    evt  = chMatch & live;
    setv = evt & chLevel & ~chMsgEn;
    fire = evt & ~chLevel & ~chMsgEn;
    q    = evt & chMsgEn;
    clr  = ~live | (statusWrEn ? statusWrData : '0) | fire;
    nStat = (mStat & ~clr) | setv;
    g = mPend & (~mPend + 1'b1);
    nPend = (mPend & ~(msgAck ? g : '0)) | q;
    @(posedge clk);
    #1;
    mStat = nStat; mPulse = fire; mPend = nPend;
    mLeg = legacyMode; mL0 = legIn0; mL1 = legIn1;
    compareAll();
  endtask

  task automatic quiet();
    chMatch = '0; statusWrEn = 1'b0; statusWrData = '0; msgAck = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 lines at reset", irqLines, '0);
    chk("R10 status at reset", statusBits, '0);
    chk("R10 legacyTimerEn at reset", legacyTimerEn, 1'b1);
    chk("R10 msgValid at reset", msgValid, 1'b0);
    rstN = 1'b1;
    globalEn = 1'b1; chEnable = '1;
    step();

    // R1 R2: level channel 2 routed to line 5, held until cleared
    chLevel = 4'b1111; chRoute[2] = 4'd5; chMatch = 4'b0100;
    step(); quiet();
    chk("R1 line 5 driven", irqLines[5], 1'b1);
    chk("R2 status bit 2 set", statusBits, 4'b0100);
    step(); step();
    chk("R2 line 5 still held", irqLines[5], 1'b1);

    // R5: clear selectivity, and event beats a same-cycle clear
    chRoute[3] = 4'd6; chMatch = 4'b1000; step(); quiet();
    statusWrEn = 1'b1; statusWrData = 4'b0100; step(); quiet();
    chk("R5 only bit 2 cleared", statusBits, 4'b1000);
    chk("R5 line 5 dropped", irqLines[5], 1'b0);
    statusWrEn = 1'b1; statusWrData = 4'b1000; chMatch = 4'b1000; step(); quiet();
    chk("R5 event wins over clear", statusBits, 4'b1000);
    statusWrEn = 1'b1; statusWrData = 4'b1111; step(); quiet();

    // R3: edge channel 3 on line 12, one cycle wide
    chLevel = 4'b0111; chRoute[3] = 4'd12; chMatch = 4'b1000;
    step(); quiet();
    chk("R3 pulse high", irqLines[12], 1'b1);
    chk("R3 status stays clear", statusBits[3], 1'b0);
    step();
    chk("R3 pulse one cycle only", irqLines[12], 1'b0);

    // R7 R8: legacy routing override
    chLevel = 4'b1111; chRoute[0] = 4'd3; chRoute[1] = 4'd4;
    legacyMode = 1'b1; step();
    chk("R8 timer enable off in legacy", legacyTimerEn, 1'b0);
    chMatch = 4'b0011; step(); quiet();
    chk("R7 lines 0 and 8 not 3 and 4", {irqLines[8], irqLines[4], irqLines[3], irqLines[0]}, 4'b1001);
    statusWrEn = 1'b1; statusWrData = 4'b1111; step(); quiet();

    // R9: legacy inputs blocked, then line 8 restored on exit
    legIn0 = 1'b1; legIn1 = 1'b1; step(); step();
    chk("R9 legacy inputs blocked", {irqLines[8], irqLines[0]}, 2'b00);
    legIn0 = 1'b0; legacyMode = 1'b0; step();
    chk("R9 line 8 restored on exit", irqLines[8], 1'b1);
    chk("R9 line 0 follows first input", irqLines[0], 1'b0);
    chk("R8 timer enable back on", legacyTimerEn, 1'b1);
    legIn1 = 1'b0; step();

    // R4: message mode, held without ack, no line
    chMsgEn = 4'b0110; chMsgWord[2] = 64'hFEE0_1000_0000_0041;
    chMsgWord[1] = 64'hFEE0_2000_0000_0022; chMatch = 4'b0100;
    step(); quiet();
    chk("R4 request raised", msgValid, 1'b1);
    chk("R4 address high half", msgAddr, 32'hFEE0_1000);
    chk("R4 data low half", msgData, 32'h0000_0041);
    chk("R4 no line driven", irqLines, '0);
    chMatch = 4'b0010; step(); quiet(); step();
    chk("R4 lower channel first", msgData, 32'h0000_0022);
    msgAck = 1'b1; step(); quiet();
    chk("R4 next request after ack", msgData, 32'h0000_0041);
    msgAck = 1'b1; step(); quiet();
    chk("R4 request dropped after ack", msgValid, 1'b0);
    chMsgEn = '0;

    // R6: disable clears and ignores
    chMatch = 4'b0001; step(); quiet();
    globalEn = 1'b0; step();
    chk("R6 global disable clears status", statusBits, 4'b0000);
    chMatch = 4'b0001; step(); quiet();
    chk("R6 event ignored while disabled", statusBits, 4'b0000);
    globalEn = 1'b1; chEnable = 4'b1110; chMatch = 4'b0001; step(); quiet();
    chk("R6 channel disable ignores event", statusBits[0], 1'b0);
    chEnable = '1;

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 24 == 0) begin
        chLevel  = NC'($urandom);
        chMsgEn  = NC'($urandom) & NC'($urandom);
        chEnable = NC'($urandom) | NC'($urandom);
        for (int c = 0; c < NC; c++) begin
          chRoute[c] = RW'($urandom);
          chMsgWord[c] = {$urandom, $urandom};
        end
        legacyMode = ($urandom % 3) == 0;
        globalEn = ($urandom % 8) != 0;
      end
      chMatch = NC'($urandom) & NC'($urandom);
      statusWrEn = ($urandom % 4) == 0;
      statusWrData = NC'($urandom);
      msgAck = ($urandom % 3) == 0;
      if ($urandom % 5 == 0) legIn0 = $urandom;
      if ($urandom % 5 == 0) legIn1 = $urandom;
      step();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule